// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives a single pulse-width-modulated output with up to ten bits of duty resolution. The time base is a 10-bit count whose upper eight bits act as the period timer and whose two lowest bits are a fine sub-step counter. The count advances by one on each clock cycle where the clock enable is high and the block is switched on. An 8-bit period value marks the last timer value of a cycle. When the count reaches that timer value with the fine bits all ones, the next step wraps the count to zero and starts a new period.

Software writes the duty value as two parts: an 8-bit high part and a 2-bit low part. Together these form a 10-bit master value. At each period boundary the master value is copied into a slave register, and the comparison only ever uses the slave. A duty write made partway through a period therefore takes effect at the start of the next period. The output is high from the start of a period until the count equals the slave duty. Clearing the enable bit forces the output low and holds the time base at zero.

All register writes are single-cycle strobes with no handshake, so a write is always accepted and there is no back-pressure. The output is a plain level.

Top module: `pwm10_gen`

## Requirements
- R1: After reset, `pwm_out` is 0, the block is disabled, and the period, master duty and slave duty are all zero.
- R2: While enabled, the 10-bit count advances by exactly one on each cycle with `clk_en` high and holds on each cycle with `clk_en` low.
- R3: The count is compared with {period, 2'b11}. On an enabled step that finds this match, the count returns to 0, so one period lasts (period+1)*4 enabled steps.
- R4: At each period boundary the output goes high, provided the new slave duty is nonzero.
- R5: Within a period the output stays high while count < slave duty. It goes low on the step where the count equals the slave duty.
- R6: The master duty is copied into the slave only at a period boundary, or continuously while the block is disabled. A master write partway through a period does not change the current period's waveform.
- R7: A slave duty greater than the last count of the period keeps the output high for the whole period.
- R8: A slave duty of 0 keeps the output low for the whole period, because the clear condition takes priority over the set.
- R9: Writing `ctrl_en`=0 with `ctrl_wr` makes `pwm_out` 0 from the next cycle and holds the count at 0. A later enable starts a fresh period at count 0 with the current master duty.
- R10: The master duty is {high part, low part}. `duty_hi_wr` loads bits 9:2 from `duty_hi_data`, and `duty_lo_wr` loads bits 1:0 from `duty_lo_data`. Each write leaves the other part unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Time-base step enable |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_en | input | 1 | Enable bit written by `ctrl_wr` |
| period_wr | input | 1 | Period register write strobe |
| period_data | input | 8 | Period value |
| duty_hi_wr | input | 1 | Duty high-part write strobe |
| duty_hi_data | input | 8 | Duty bits 9:2 |
| duty_lo_wr | input | 1 | Duty low-part write strobe |
| duty_lo_data | input | 2 | Duty bits 1:0 |
| pwm_out | output | 1 | PWM output |

## Verification
A count that drifts or skips shows up as a period whose length differs from (period+1)*4 steps, or as a high phase that ends one step early or late. The bench compares the output with its model on every cycle, so such an error shows within one period. A slave register that loads at the wrong time makes the output follow a mid-period duty write at once instead of at the next boundary. That mismatch shows within the same period. A wrong priority between set and clear shows on the first boundary that has a duty of zero.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int unsigned TMR_W_DEF  = 8;
  localparam int unsigned FRAC_W_DEF = 2;

  // Time-base position split into coarse timer and fine sub-step
  function automatic logic [TMR_W_DEF+FRAC_W_DEF-1:0] join_pos(
    input logic [TMR_W_DEF-1:0]  coarse,
    input logic [FRAC_W_DEF-1:0] fine);
    return {coarse, fine};
  endfunction
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned CNT_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_en,
  input  logic              period_wr,
  input  logic [TMR_W-1:0]  period_data,
  input  logic              duty_hi_wr,
  input  logic [TMR_W-1:0]  duty_hi_data,
  input  logic              duty_lo_wr,
  input  logic [FRAC_W-1:0] duty_lo_data,
  output logic              en_q,
  output logic [TMR_W-1:0]  period_q,
  output logic [CNT_W-1:0]  master_q
);
  logic [TMR_W-1:0]  hi_q;
  logic [FRAC_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      period_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      if (ctrl_wr)    en_q     <= ctrl_en;
      if (period_wr)  period_q <= period_data;
      if (duty_hi_wr) hi_q     <= duty_hi_data;
      if (duty_lo_wr) lo_q     <= duty_lo_data;
    end
  end

  assign master_q = {hi_q, lo_q};
endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned CNT_W = TMR_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             clk_en,
  input  logic [TMR_W-1:0] period_q,
  output logic [CNT_W-1:0] tb_cnt,
  output logic             step,
  output logic             period_match
);
  localparam logic [FRAC_W-1:0] FINE_LAST = {FRAC_W{1'b1}};

  assign step         = en_q & clk_en;
  assign period_match = (tb_cnt == {period_q, FINE_LAST});

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      tb_cnt <= '0;
    end else if (step) begin
      if (period_match) tb_cnt <= '0;
      else              tb_cnt <= tb_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm10_duty.sv
module pwm10_duty #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             step,
  input  logic             period_match,
  input  logic [CNT_W-1:0] tb_cnt,
  input  logic [CNT_W-1:0] master_q,
  output logic [CNT_W-1:0] duty_slave,
  output logic             out_q
);
  logic [CNT_W-1:0] cnt_next;
  assign cnt_next = tb_cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_slave <= '0;
      out_q      <= 1'b0;
    end else if (!en_q) begin
      // Idle: track master and preset the latch for a period start
      duty_slave <= master_q;
      out_q      <= (master_q != '0);
    end else if (step) begin
      if (period_match) begin
        duty_slave <= master_q;
        out_q      <= (master_q != '0);   // clear wins over set
      end else begin
        out_q      <= out_q & (cnt_next != duty_slave);
      end
    end
  end
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int unsigned TMR_W  = TMR_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  localparam int unsigned CNT_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              ctrl_wr,
  input  logic              ctrl_en,
  input  logic              period_wr,
  input  logic [TMR_W-1:0]  period_data,
  input  logic              duty_hi_wr,
  input  logic [TMR_W-1:0]  duty_hi_data,
  input  logic              duty_lo_wr,
  input  logic [FRAC_W-1:0] duty_lo_data,
  output logic              pwm_out
);
  logic             en_q;
  logic [TMR_W-1:0] period_q;
  logic [CNT_W-1:0] master_q;
  logic [CNT_W-1:0] tb_cnt;
  logic             step;
  logic             period_match;
  logic [CNT_W-1:0] duty_slave;
  logic             out_q;

  pwm10_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
    .period_wr(period_wr), .period_data(period_data),
    .duty_hi_wr(duty_hi_wr), .duty_hi_data(duty_hi_data),
    .duty_lo_wr(duty_lo_wr), .duty_lo_data(duty_lo_data),
    .en_q(en_q), .period_q(period_q), .master_q(master_q)
  );

  pwm10_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .clk_en(clk_en),
    .period_q(period_q), .tb_cnt(tb_cnt), .step(step),
    .period_match(period_match)
  );

  pwm10_duty #(.CNT_W(CNT_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .step(step),
    .period_match(period_match), .tb_cnt(tb_cnt), .master_q(master_q),
    .duty_slave(duty_slave), .out_q(out_q)
  );

  assign pwm_out = en_q & out_q;
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             ctrl_wr,
  input logic             ctrl_en,
  input logic             en_q,
  input logic             period_match,
  input logic [CNT_W-1:0] tb_cnt,
  input logic [CNT_W-1:0] duty_slave,
  input logic             pwm_out
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !clk_en && !(ctrl_wr && !ctrl_en)) |=> (tb_cnt == $past(tb_cnt)));

  // R3
  wrap_at_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && clk_en && period_match) |=> (tb_cnt == '0));

  // R6
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !(clk_en && period_match)) |=> $stable(duty_slave));

  // R8
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && duty_slave == '0) |-> !pwm_out);

  // R9
  disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_en) |=> !pwm_out);

  // R5
  duty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && clk_en && !period_match && (tb_cnt + CNT_W'(1)) == duty_slave)
      |=> !pwm_out);
endmodule

bind pwm10_gen pwm10_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ctrl_wr(ctrl_wr),
  .ctrl_en(ctrl_en), .en_q(en_q), .period_match(period_match),
  .tb_cnt(tb_cnt), .duty_slave(duty_slave), .pwm_out(pwm_out)
);

// File: tb/sim_pwm10_gen.sv
module sim_pwm10_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_en;
  logic       ctrl_wr, ctrl_en, period_wr, duty_hi_wr, duty_lo_wr;
  logic [7:0] period_data, duty_hi_data;
  logic [1:0] duty_lo_data;
  logic       pwm_out;

  int n_cmp  = 0;
  int n_fail = 0;
  int cyc_n  = 0;
  bit done   = 0;

  // Reference state
  bit       m_en;
  bit [7:0] m_pr, m_hi;
  bit [1:0] m_lo;
  bit [9:0] m_slave, m_cnt;

  always #5 clk = ~clk;

  pwm10_gen u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
    .period_wr(period_wr), .period_data(period_data),
    .duty_hi_wr(duty_hi_wr), .duty_hi_data(duty_hi_data),
    .duty_lo_wr(duty_lo_wr), .duty_lo_data(duty_lo_data),
    .pwm_out(pwm_out)
  );

  function automatic bit exp_out();
    return m_en && (m_cnt < m_slave);
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_out=%0d expected %0d (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  task automatic idle_inputs();
    ctrl_wr = 0; period_wr = 0; duty_hi_wr = 0; duty_lo_wr = 0;
  endtask

  // One clock: update reference with current inputs, compare at negedge
  task automatic tick(input string tag);
    bit [9:0] mst;
    @(posedge clk);
    cyc_n++;
    if (!rst_n) begin
      m_en = 0; m_pr = 0; m_hi = 0; m_lo = 0; m_slave = 0; m_cnt = 0;
    end else begin
      mst = {m_hi, m_lo};
      if (!m_en) begin
        m_cnt = 0; m_slave = mst;
      end else if (clk_en) begin
        if (m_cnt == {m_pr, 2'b11}) begin m_cnt = 0; m_slave = mst; end
        else m_cnt = m_cnt + 10'd1;
      end
      if (ctrl_wr)    m_en = ctrl_en;
      if (period_wr)  m_pr = period_data;
      if (duty_hi_wr) m_hi = duty_hi_data;
      if (duty_lo_wr) m_lo = duty_lo_data;
    end
    @(negedge clk);
    check(tag, pwm_out, exp_out());
    idle_inputs();
  endtask

  task automatic set_en(input bit v, input string tag);
    ctrl_wr = 1; ctrl_en = v; tick(tag);
  endtask

  task automatic set_period(input bit [7:0] v, input string tag);
    period_wr = 1; period_data = v; tick(tag);
  endtask

  task automatic set_duty(input bit [9:0] v, input string tag);
    duty_hi_wr = 1; duty_hi_data = v[9:2];
    duty_lo_wr = 1; duty_lo_data = v[1:0];
    tick(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    int hi_cnt;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    idle_inputs();
    clk_en = 1; ctrl_en = 0;
    period_data = 0; duty_hi_data = 0; duty_lo_data = 0;
    rst_n = 0;
    @(negedge clk);
    run(3, "R1 reset");
    rst_n = 1;
    run(2, "R1 after reset");
    check("R1 output low", pwm_out, 1'b0);

    // R10: duty 5 built from separate parts, period 3 -> 16 steps
    set_period(8'd3, "R3 setup");
    duty_hi_wr = 1; duty_hi_data = 8'd1; tick("R10 hi part");
    duty_lo_wr = 1; duty_lo_data = 2'd1; tick("R10 lo part");
    set_en(1, "R4 enable");
    hi_cnt = 0;
    for (int i = 0; i < 16; i++) begin
      tick("R5 duty 5");
      if (pwm_out) hi_cnt++;
    end
    n_cmp++;
    if (hi_cnt != 5) begin
      n_fail++;
      $display("FAIL R10/R5: high steps=%0d expected 5", hi_cnt);
    end
    run(32, "R3 R4 R5 steady");

    // R6: mid-period rewrite must wait for the boundary
    run(3, "R6 pre");
    set_duty(10'd12, "R6 mid write");
    run(40, "R6 after");

    // R2: clk_en gaps
    for (int i = 0; i < 60; i++) begin
      clk_en = (i % 3) != 0;
      tick("R2 gated");
    end
    clk_en = 1;

    // R8: zero duty
    set_duty(10'd0, "R8 write");
    run(40, "R8 zero duty");

    // R7: duty beyond the span
    set_duty(10'd100, "R7 write");
    run(40, "R7 full high");

    // R9: disable mid-period, then restart
    run(5, "R9 pre");
    set_en(0, "R9 disable");
    check("R9 forced low", pwm_out, 1'b0);
    run(6, "R9 idle");
    set_duty(10'd3, "R9 duty");
    set_en(1, "R9 restart");
    run(20, "R9 fresh period");

    // Random phases
    for (int ph = 0; ph < 150; ph++) begin
      set_en(0, "R9 rnd off");
      set_period(8'($urandom_range(0, 9)), "R3 rnd period");
      set_duty(10'($urandom_range(0, 45)), "R10 rnd duty");
      set_en(1, "R4 rnd on");
      for (int i = 0; i < 120; i++) begin
        clk_en = ($urandom_range(0, 9) < 7);
        if ($urandom_range(0, 29) == 0) begin
          duty_hi_wr = 1; duty_hi_data = 8'($urandom_range(0, 11));
        end
        if ($urandom_range(0, 29) == 0) begin
          duty_lo_wr = 1; duty_lo_data = 2'($urandom_range(0, 3));
        end
        tick("R5 R6 rnd");
      end
      clk_en = 1;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule